// File: doc/BRIEF.md
# Mip Chain Surface Sizer

This engine computes the memory footprint of a micro-tiled texture across its whole mip chain. A client presents the base geometry: width, height, depth and pitch, the element size in bits, an optional block-compression flag, the texture kind, the sample count, the tile mode and a power-of-two padding flag. It then pulses `start`. The engine captures that description and steps through the levels one after another.

For each level it derives the unpadded and padded dimensions. It widens the slice pitch in steps of eight elements until one physical slice fills whole pipe-interleave units, which takes one step per clock. When the level is settled it emits a single-cycle result with the padded pitch, height and depth, the level's byte offset, its tiled size and its linear size. The last level's result comes with a completion pulse that carries the total surface size.

A description the engine cannot handle is rejected at once with an error flag. It never produces a level result.

Top module: `mip_chain_sizer`

## Requirements
- R1: After reset, `busy`, `lvl_done`, `all_done` and `cfg_err` are all low.
- R2: A `start` seen while idle with a valid description raises `busy` on the next cycle. A `start` seen while `busy` is high is ignored, and the running computation keeps producing the results of the description captured first.
- R3: At level L each base dimension (width, height, pitch, and depth for the volume kind) is shifted right by L and clamped to at least 1. For every kind other than volume the per-level depth is 1. Kind codes: 0 plain, 1 cube, 2 volume, 3 multisample. `lvl_index` reports L, counting from 0.
- R4: With `in_bc` set and element bits 1, the element size is multiplied by 8 and the level width and pitch become ceil(x/8). With element bits 4 or 8, the element size is multiplied by 16 and the level width, pitch and height become ceil(x/4).
- R5: `cfg_err` and `all_done` rise one cycle after `start` if the description is invalid. Invalid means `in_bc` set with element bits other than 1, 4 or 8, or tile mode 2 or 3, or a level count of 0. In that case no level result appears and `busy` stays low. `cfg_err` holds until the next accepted `start`.
- R6: With `in_pow2` set, the array slice count and each level's pitch, width, height and depth are rounded up to the next power of two (taken after step R4).
- R7: Above level 0, when the base pitch is nonzero, the level pitch is replaced by the level width.
- R8: The output pitch and height are multiples of 8. The output depth is the level depth rounded up to the tile thickness (tile mode 0 gives 1, tile mode 1 gives 4), except for the cube kind, which keeps the level depth unchanged.
- R9: The output pitch is the smallest value of (pitch rounded to 8) + 8k for which ceil(pitch*height*bits*samples/8) times the thickness is a multiple of PIPE_BYTES (default 256).
- R10: The samples factor is 2^`in_samples_log2` for the multisample kind and 1 otherwise. The tiled size is the slice bytes of R9 times the output depth. The linear size is the level depth times ceil(level pitch*level height*bits*samples/8), using the pitch after R7.
- R11: Level 0 has offset 0. Each next level's offset advances by the slice count times the tiled size. The slice count is the depth for plain and multisample, six times the depth for cube, and 1 for volume.
- R12: `all_done` pulses in the same cycle as the last level's `lvl_done`, with `total_size` equal to the offset after the last level, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation when idle |
| in_width | input | DIM_W | Base width in texels |
| in_height | input | DIM_W | Base height in texels |
| in_depth | input | DIM_W | Base depth or array layer count |
| in_pitch | input | DIM_W | Base pitch in texels, 0 if none |
| in_elem_bits | input | EB_W | Bits per fragment |
| in_bc | input | 1 | Block-compressed format |
| in_kind | input | 2 | Texture kind code |
| in_samples_log2 | input | 2 | Log2 of the sample count |
| in_tile_mode | input | 2 | 0 thin, 1 thick, others unsupported |
| in_pow2 | input | 1 | Power-of-two padding |
| in_levels | input | LVL_W | Number of mip levels |
| busy | output | 1 | Computation in progress |
| lvl_done | output | 1 | One-cycle level result strobe |
| lvl_index | output | LVL_W | Level of the current result |
| lvl_pitch | output | DIM_W+4 | Padded, grown pitch |
| lvl_height | output | DIM_W+4 | Padded height |
| lvl_depth | output | DIM_W+4 | Padded depth |
| lvl_offset | output | SZ_W | Byte offset of the level |
| lvl_tiled | output | SZ_W | Tiled size of one slice set |
| lvl_linear | output | SZ_W | Linear size |
| all_done | output | 1 | Completion or rejection pulse |
| total_size | output | SZ_W | Total surface bytes |
| cfg_err | output | 1 | Unsupported description |

## Verification
On every cycle the assertions check the handshake invariants: results appear only during a run, the captured description does not move while busy, a rejection strobes completion without a level result, and completion coincides with the last level and with leaving the busy state. They also check the alignment properties of every emitted level, meaning pitch and height are multiples of eight and the tiled size is pipe-interleave aligned when the depth is a multiple of the thickness. The exact numeric values can only be shown by the bench's sweep, which covers texture kinds, tile modes, padding, compressed formats, zero and nonzero pitch, an ignored mid-run start and each rejection cause. Those values are the growth count, the block-compression reductions, the pitch replacement, the offsets and the totals.

// File: rtl/mip_pkg.sv
package mip_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'd0,
    KIND_CUBE   = 2'd1,
    KIND_VOLUME = 2'd2,
    KIND_MSAA   = 2'd3
  } tex_kind_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_DIV8 = 2'd1,
    BC_DIV4 = 2'd2
  } bc_class_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_GROW  = 2'd2
  } eng_state_e;

  localparam int unsigned TILE_EDGE = 8;
endpackage

// File: rtl/mip_cfg_decode.sv
module mip_cfg_decode
  import mip_pkg::*;
#(
  parameter int unsigned DIM_W = 14,
  parameter int unsigned EB_W  = 8,
  parameter int unsigned LVL_W = 4,
  parameter int unsigned BPE_W = EB_W + 4,
  parameter int unsigned SL_W  = DIM_W + 4
) (
  input  logic [DIM_W-1:0] depth_i,
  input  logic [EB_W-1:0]  elem_bits_i,
  input  logic             bc_i,
  input  tex_kind_e        kind_i,
  input  logic [1:0]       tile_mode_i,
  input  logic             pow2_i,
  input  logic [LVL_W-1:0] levels_i,
  output logic             err_o,
  output logic [BPE_W-1:0] bpe_o,
  output bc_class_e        bc_cls_o,
  output logic [3:0]       thick_o,
  output logic [SL_W-1:0]  slices_o,
  output logic [DIM_W-1:0] vol_depth_o
);
  logic             bc_bad;
  logic             tm_bad;
  logic [SL_W-1:0]  slices_raw;

  function automatic logic [SL_W-1:0] ceil_pow2(input logic [SL_W-1:0] v);
    logic [SL_W-1:0] r;
    r = '0;
    for (int k = SL_W - 1; k >= 0; k--) begin
      if ((SL_W'(1) << k) >= v) r = SL_W'(1) << k;
    end
    return r;
  endfunction

  always_comb begin
    bc_bad   = 1'b0;
    bc_cls_o = BC_NONE;
    bpe_o    = BPE_W'(elem_bits_i);
    if (bc_i) begin
      case (elem_bits_i)
        EB_W'(1): begin
          bc_cls_o = BC_DIV8;
          bpe_o    = BPE_W'(elem_bits_i) << 3;
        end
        EB_W'(4), EB_W'(8): begin
          bc_cls_o = BC_DIV4;
          bpe_o    = BPE_W'(elem_bits_i) << 4;
        end
        default: bc_bad = 1'b1;
      endcase
    end
  end

  always_comb begin
    tm_bad = 1'b0;
    case (tile_mode_i)
      2'd0:    thick_o = 4'd1;
      2'd1:    thick_o = 4'd4;
      default: begin
        thick_o = 4'd1;
        tm_bad  = 1'b1;
      end
    endcase
  end

  always_comb begin
    case (kind_i)
      KIND_CUBE:   slices_raw = SL_W'(depth_i) * SL_W'(6);
      KIND_VOLUME: slices_raw = SL_W'(1);
      default:     slices_raw = SL_W'(depth_i);
    endcase
    slices_o    = pow2_i ? ceil_pow2(slices_raw) : slices_raw;
    vol_depth_o = (kind_i == KIND_VOLUME) ? depth_i : DIM_W'(1);
  end

  assign err_o = bc_bad | tm_bad | (levels_i == '0);
endmodule

// File: rtl/mip_level_geom.sv
module mip_level_geom
  import mip_pkg::*;
#(
  parameter int unsigned DIM_W = 14,
  parameter int unsigned LVL_W = 4,
  parameter int unsigned XW    = DIM_W + 4
) (
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  input  logic [DIM_W-1:0] pitch_i,
  input  logic [DIM_W-1:0] vdepth_i,
  input  logic [LVL_W-1:0] level_i,
  input  bc_class_e        bc_cls_i,
  input  logic             pow2_i,
  input  logic             is_cube_i,
  input  logic [3:0]       thick_i,
  output logic [XW-1:0]    lin_pitch_o,
  output logic [XW-1:0]    lin_height_o,
  output logic [XW-1:0]    lin_depth_o,
  output logic [XW-1:0]    pad_pitch_o,
  output logic [XW-1:0]    pad_height_o,
  output logic [XW-1:0]    pad_depth_o
);
  localparam logic [XW-1:0] EDGE_M1 = XW'(TILE_EDGE - 1);

  logic [XW-1:0] w, h, p, d;
  logic [XW-1:0] thick_m1;

  function automatic logic [XW-1:0] shr_clamp(input logic [DIM_W-1:0] v,
                                               input logic [LVL_W-1:0] lvl);
    logic [XW-1:0] t;
    t = XW'(v >> lvl);
    if (t == '0) t = XW'(1);
    return t;
  endfunction

  function automatic logic [XW-1:0] cdiv_pow2(input logic [XW-1:0] v,
                                              input int unsigned sh);
    logic [XW-1:0] t;
    t = (v + ((XW'(1) << sh) - XW'(1))) >> sh;
    if (t == '0) t = XW'(1);
    return t;
  endfunction

  function automatic logic [XW-1:0] ceil_pow2(input logic [XW-1:0] v);
    logic [XW-1:0] r;
    r = '0;
    for (int k = XW - 1; k >= 0; k--) begin
      if ((XW'(1) << k) >= v) r = XW'(1) << k;
    end
    return r;
  endfunction

  always_comb begin
    w = shr_clamp(width_i, level_i);
    h = shr_clamp(height_i, level_i);
    p = shr_clamp(pitch_i, level_i);
    d = shr_clamp(vdepth_i, level_i);
    case (bc_cls_i)
      BC_DIV8: begin
        w = cdiv_pow2(w, 3);
        p = cdiv_pow2(p, 3);
      end
      BC_DIV4: begin
        w = cdiv_pow2(w, 2);
        p = cdiv_pow2(p, 2);
        h = cdiv_pow2(h, 2);
      end
      default: ;
    endcase
    if (pow2_i) begin
      w = ceil_pow2(w);
      p = ceil_pow2(p);
      h = ceil_pow2(h);
      d = ceil_pow2(d);
    end
    if ((level_i != '0) && (pitch_i != '0)) p = w;
  end

  assign thick_m1     = XW'(thick_i) - XW'(1);
  assign lin_pitch_o  = p;
  assign lin_height_o = h;
  assign lin_depth_o  = d;
  assign pad_pitch_o  = (p + EDGE_M1) & ~EDGE_M1;
  assign pad_height_o = (h + EDGE_M1) & ~EDGE_M1;
  assign pad_depth_o  = is_cube_i ? d : ((d + thick_m1) & ~thick_m1);
endmodule

// File: rtl/mip_slice_sizer.sv
module mip_slice_sizer #(
  parameter int unsigned XW         = 18,
  parameter int unsigned BPE_W      = 12,
  parameter int unsigned SZ_W       = 48,
  parameter int unsigned PIPE_BYTES = 256
) (
  input  logic [XW-1:0]    pitch_i,
  input  logic [XW-1:0]    height_i,
  input  logic [BPE_W-1:0] bpe_i,
  input  logic [1:0]       samp_log_i,
  input  logic [3:0]       thick_i,
  output logic [SZ_W-1:0]  bytes_o,
  output logic             aligned_o
);
  localparam int unsigned PI_LG = $clog2(PIPE_BYTES);

  logic [SZ_W-1:0] bits;
  logic [SZ_W-1:0] phys;

  assign bits      = (SZ_W'(pitch_i) * SZ_W'(height_i) * SZ_W'(bpe_i)) << samp_log_i;
  assign bytes_o   = (bits + SZ_W'(7)) >> 3;
  assign phys      = bytes_o * SZ_W'(thick_i);
  assign aligned_o = (phys[PI_LG-1:0] == '0);
endmodule

// File: rtl/mip_chain_sizer.sv
module mip_chain_sizer
  import mip_pkg::*;
#(
  parameter int unsigned DIM_W      = 14,
  parameter int unsigned EB_W       = 8,
  parameter int unsigned LVL_W      = 4,
  parameter int unsigned SZ_W       = 48,
  parameter int unsigned PIPE_BYTES = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DIM_W-1:0]   in_width,
  input  logic [DIM_W-1:0]   in_height,
  input  logic [DIM_W-1:0]   in_depth,
  input  logic [DIM_W-1:0]   in_pitch,
  input  logic [EB_W-1:0]    in_elem_bits,
  input  logic               in_bc,
  input  logic [1:0]         in_kind,
  input  logic [1:0]         in_samples_log2,
  input  logic [1:0]         in_tile_mode,
  input  logic               in_pow2,
  input  logic [LVL_W-1:0]   in_levels,
  output logic               busy,
  output logic               lvl_done,
  output logic [LVL_W-1:0]   lvl_index,
  output logic [DIM_W+3:0]   lvl_pitch,
  output logic [DIM_W+3:0]   lvl_height,
  output logic [DIM_W+3:0]   lvl_depth,
  output logic [SZ_W-1:0]    lvl_offset,
  output logic [SZ_W-1:0]    lvl_tiled,
  output logic [SZ_W-1:0]    lvl_linear,
  output logic               all_done,
  output logic [SZ_W-1:0]    total_size,
  output logic               cfg_err
);
  localparam int unsigned XW    = DIM_W + 4;
  localparam int unsigned BPE_W = EB_W + 4;
  localparam int unsigned SL_W  = DIM_W + 4;

  tex_kind_e kind_in;
  assign kind_in = tex_kind_e'(in_kind);

  // decoded description
  logic             dec_err;
  logic [BPE_W-1:0] dec_bpe;
  bc_class_e        dec_bc_cls;
  logic [3:0]       dec_thick;
  logic [SL_W-1:0]  dec_slices;
  logic [DIM_W-1:0] dec_vdepth;

  mip_cfg_decode #(
    .DIM_W(DIM_W), .EB_W(EB_W), .LVL_W(LVL_W), .BPE_W(BPE_W), .SL_W(SL_W)
  ) u_decode (
    .depth_i    (in_depth),
    .elem_bits_i(in_elem_bits),
    .bc_i       (in_bc),
    .kind_i     (kind_in),
    .tile_mode_i(in_tile_mode),
    .pow2_i     (in_pow2),
    .levels_i   (in_levels),
    .err_o      (dec_err),
    .bpe_o      (dec_bpe),
    .bc_cls_o   (dec_bc_cls),
    .thick_o    (dec_thick),
    .slices_o   (dec_slices),
    .vol_depth_o(dec_vdepth)
  );

  // captured description
  logic [DIM_W-1:0] width_q, height_q, pitch_q, vdepth_q;
  logic [BPE_W-1:0] bpe_q;
  bc_class_e        bc_cls_q;
  logic [3:0]       thick_q;
  logic [SL_W-1:0]  slices_q;
  logic [1:0]       samp_q;
  logic             pow2_q;
  logic             cube_q;
  logic [LVL_W-1:0] last_q;

  // engine state
  eng_state_e       state_q, state_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic [XW-1:0]    grow_q, grow_d;
  logic [SZ_W-1:0]  offset_q, offset_d;
  logic             err_q, err_d;
  logic             all_done_q, all_done_d;
  logic [SZ_W-1:0]  total_q, total_d;
  logic             lvl_done_q;

  logic accept, cfg_load, emit;

  // level geometry
  logic [XW-1:0] lin_p, lin_h, lin_d, pad_p, pad_h, pad_d;

  mip_level_geom #(
    .DIM_W(DIM_W), .LVL_W(LVL_W), .XW(XW)
  ) u_geom (
    .width_i     (width_q),
    .height_i    (height_q),
    .pitch_i     (pitch_q),
    .vdepth_i    (vdepth_q),
    .level_i     (level_q),
    .bc_cls_i    (bc_cls_q),
    .pow2_i      (pow2_q),
    .is_cube_i   (cube_q),
    .thick_i     (thick_q),
    .lin_pitch_o (lin_p),
    .lin_height_o(lin_h),
    .lin_depth_o (lin_d),
    .pad_pitch_o (pad_p),
    .pad_height_o(pad_h),
    .pad_depth_o (pad_d)
  );

  logic [SZ_W-1:0] slice_bytes;
  logic            slice_aligned;

  mip_slice_sizer #(
    .XW(XW), .BPE_W(BPE_W), .SZ_W(SZ_W), .PIPE_BYTES(PIPE_BYTES)
  ) u_sizer (
    .pitch_i   (grow_q),
    .height_i  (pad_h),
    .bpe_i     (bpe_q),
    .samp_log_i(samp_q),
    .thick_i   (thick_q),
    .bytes_o   (slice_bytes),
    .aligned_o (slice_aligned)
  );

  logic [SZ_W-1:0] tiled_w, linear_w, lin_bits, advance_w;

  assign tiled_w   = slice_bytes * SZ_W'(pad_d);
  assign lin_bits  = (SZ_W'(lin_p) * SZ_W'(lin_h) * SZ_W'(bpe_q)) << samp_q;
  assign linear_w  = SZ_W'(lin_d) * ((lin_bits + SZ_W'(7)) >> 3);
  assign advance_w = SZ_W'(slices_q) * tiled_w;

  assign accept   = start && (state_q == ST_IDLE);
  assign cfg_load = accept && !dec_err;
  assign emit     = (state_q == ST_GROW) && slice_aligned;

  // next state
  always_comb begin
    state_d    = state_q;
    level_d    = level_q;
    grow_d     = grow_q;
    offset_d   = offset_q;
    err_d      = err_q;
    all_done_d = 1'b0;
    total_d    = total_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (dec_err) begin
            err_d      = 1'b1;
            all_done_d = 1'b1;
            total_d    = '0;
          end else begin
            err_d    = 1'b0;
            state_d  = ST_SETUP;
            level_d  = '0;
            offset_d = '0;
          end
        end
      end
      ST_SETUP: begin
        grow_d  = pad_p;
        state_d = ST_GROW;
      end
      ST_GROW: begin
        if (!slice_aligned) begin
          grow_d = grow_q + XW'(TILE_EDGE);
        end else begin
          offset_d = offset_q + advance_w;
          if (level_q == last_q) begin
            state_d    = ST_IDLE;
            all_done_d = 1'b1;
            total_d    = offset_q + advance_w;
          end else begin
            level_d = level_q + LVL_W'(1);
            state_d = ST_SETUP;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // engine registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      level_q    <= '0;
      grow_q     <= '0;
      offset_q   <= '0;
      err_q      <= 1'b0;
      all_done_q <= 1'b0;
      total_q    <= '0;
      lvl_done_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      level_q    <= level_d;
      grow_q     <= grow_d;
      offset_q   <= offset_d;
      err_q      <= err_d;
      all_done_q <= all_done_d;
      total_q    <= total_d;
      lvl_done_q <= emit;
    end
  end

  // description capture, enabled by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= '0;
      height_q <= '0;
      pitch_q  <= '0;
      vdepth_q <= '0;
      bpe_q    <= '0;
      bc_cls_q <= BC_NONE;
      thick_q  <= 4'd1;
      slices_q <= '0;
      samp_q   <= '0;
      pow2_q   <= 1'b0;
      cube_q   <= 1'b0;
      last_q   <= '0;
    end else if (cfg_load) begin
      width_q  <= in_width;
      height_q <= in_height;
      pitch_q  <= in_pitch;
      vdepth_q <= dec_vdepth;
      bpe_q    <= dec_bpe;
      bc_cls_q <= dec_bc_cls;
      thick_q  <= dec_thick;
      slices_q <= dec_slices;
      samp_q   <= (kind_in == KIND_MSAA) ? in_samples_log2 : 2'd0;
      pow2_q   <= in_pow2;
      cube_q   <= (kind_in == KIND_CUBE);
      last_q   <= in_levels - LVL_W'(1);
    end
  end

  // level result registers, enabled by emit
  logic [LVL_W-1:0] idx_q;
  logic [XW-1:0]    rp_q, rh_q, rd_q;
  logic [SZ_W-1:0]  roff_q, rtiled_q, rlin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      rp_q     <= '0;
      rh_q     <= '0;
      rd_q     <= '0;
      roff_q   <= '0;
      rtiled_q <= '0;
      rlin_q   <= '0;
    end else if (emit) begin
      idx_q    <= level_q;
      rp_q     <= grow_q;
      rh_q     <= pad_h;
      rd_q     <= pad_d;
      roff_q   <= offset_q;
      rtiled_q <= tiled_w;
      rlin_q   <= linear_w;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign lvl_done   = lvl_done_q;
  assign lvl_index  = idx_q;
  assign lvl_pitch  = rp_q;
  assign lvl_height = rh_q;
  assign lvl_depth  = rd_q;
  assign lvl_offset = roff_q;
  assign lvl_tiled  = rtiled_q;
  assign lvl_linear = rlin_q;
  assign all_done   = all_done_q;
  assign total_size = total_q;
  assign cfg_err    = err_q;
endmodule

// File: rtl/mip_chain_sizer_chk.sv
module mip_chain_sizer_chk #(
  parameter int unsigned XW         = 18,
  parameter int unsigned DIM_W      = 14,
  parameter int unsigned SZ_W       = 48,
  parameter int unsigned PIPE_BYTES = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             lvl_done,
  input logic             all_done,
  input logic             cfg_err,
  input logic [XW-1:0]    lvl_pitch,
  input logic [XW-1:0]    lvl_height,
  input logic [XW-1:0]    lvl_depth,
  input logic [SZ_W-1:0]  lvl_tiled,
  input logic [3:0]       thick_cfg,
  input logic [DIM_W-1:0] width_cfg
);
  localparam int unsigned PI_LG = $clog2(PIPE_BYTES);

  assert_result_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_done |-> $past(busy));

  assert_cfg_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(width_cfg));

  assert_reject_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> (all_done && !lvl_done && !busy));

  assert_tile_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_done |-> ((lvl_pitch[2:0] == 3'd0) && (lvl_height[2:0] == 3'd0)));

  assert_interleave_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_done && ((lvl_depth & (XW'(thick_cfg) - XW'(1))) == '0))
      |-> (lvl_tiled[PI_LG-1:0] == '0));

  assert_idle_at_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> !busy);

  assert_last_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (all_done && !cfg_err) |-> lvl_done);
endmodule

bind mip_chain_sizer mip_chain_sizer_chk #(
  .XW(DIM_W + 4), .DIM_W(DIM_W), .SZ_W(SZ_W), .PIPE_BYTES(PIPE_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .lvl_done  (lvl_done),
  .all_done  (all_done),
  .cfg_err   (cfg_err),
  .lvl_pitch (lvl_pitch),
  .lvl_height(lvl_height),
  .lvl_depth (lvl_depth),
  .lvl_tiled (lvl_tiled),
  .thick_cfg (thick_q),
  .width_cfg (width_q)
);

// File: tb/mip_chain_sizer_tb.sv
`timescale 1ns/1ps
module mip_chain_sizer_tb;
  localparam int DIM_W = 14;
  localparam int EB_W  = 8;
  localparam int LVL_W = 4;
  localparam int SZ_W  = 48;
  localparam longint PIPE = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [DIM_W-1:0] in_width, in_height, in_depth, in_pitch;
  logic [EB_W-1:0]  in_elem_bits;
  logic             in_bc;
  logic [1:0]       in_kind, in_samples_log2, in_tile_mode;
  logic             in_pow2;
  logic [LVL_W-1:0] in_levels;
  logic             busy, lvl_done, all_done, cfg_err;
  logic [LVL_W-1:0] lvl_index;
  logic [DIM_W+3:0] lvl_pitch, lvl_height, lvl_depth;
  logic [SZ_W-1:0]  lvl_offset, lvl_tiled, lvl_linear, total_size;

  int checks = 0;
  int fails  = 0;

  longint e_pitch[16], e_height[16], e_depth[16], e_off[16], e_tiled[16], e_lin[16];
  longint e_total;

  always #4 clk = ~clk;

  mip_chain_sizer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_width(in_width), .in_height(in_height), .in_depth(in_depth),
    .in_pitch(in_pitch), .in_elem_bits(in_elem_bits), .in_bc(in_bc),
    .in_kind(in_kind), .in_samples_log2(in_samples_log2),
    .in_tile_mode(in_tile_mode), .in_pow2(in_pow2), .in_levels(in_levels),
    .busy(busy), .lvl_done(lvl_done), .lvl_index(lvl_index),
    .lvl_pitch(lvl_pitch), .lvl_height(lvl_height), .lvl_depth(lvl_depth),
    .lvl_offset(lvl_offset), .lvl_tiled(lvl_tiled), .lvl_linear(lvl_linear),
    .all_done(all_done), .total_size(total_size), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint pow2up(input longint v);
    longint r = 1;
    while (r < v) r = r * 2;
    return r;
  endfunction

  function automatic longint atleast1(input longint v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic model(input int w, h, d, p, eb, bc, kind, sl, tm, p2, nl);
    longint bpe, samp, thick, slices, vd, off;
    int cls;
    bpe = eb; cls = 0;
    if (bc != 0) begin
      if (eb == 1) begin bpe = eb * 8; cls = 1; end
      else begin bpe = eb * 16; cls = 2; end
    end
    samp   = (kind == 3) ? (64'd1 << sl) : 1;
    thick  = (tm == 1) ? 4 : 1;
    slices = (kind == 1) ? 6 * d : (kind == 2) ? 1 : d;
    if (p2 != 0) slices = pow2up(slices);
    vd  = (kind == 2) ? d : 1;
    off = 0;
    for (int L = 0; L < nl; L++) begin
      longint lw, lh, lp, ld, pp, ph, pd, sb;
      lw = atleast1(w >> L); lh = atleast1(h >> L);
      lp = atleast1(p >> L); ld = atleast1(vd >> L);
      if (cls == 1) begin
        lw = atleast1((lw + 7) / 8); lp = atleast1((lp + 7) / 8);
      end else if (cls == 2) begin
        lw = atleast1((lw + 3) / 4); lp = atleast1((lp + 3) / 4);
        lh = atleast1((lh + 3) / 4);
      end
      if (p2 != 0) begin
        lw = pow2up(lw); lp = pow2up(lp); lh = pow2up(lh); ld = pow2up(ld);
      end
      if (L > 0 && p != 0) lp = lw;
      pp = ((lp + 7) / 8) * 8;
      ph = ((lh + 7) / 8) * 8;
      pd = (kind == 1) ? ld : ((ld + thick - 1) / thick) * thick;
      sb = (pp * ph * bpe * samp + 7) / 8;
      while (((sb * thick) % PIPE) != 0) begin
        pp = pp + 8;
        sb = (pp * ph * bpe * samp + 7) / 8;
      end
      e_pitch[L]  = pp;
      e_height[L] = ph;
      e_depth[L]  = pd;
      e_off[L]    = off;
      e_tiled[L]  = sb * pd;
      e_lin[L]    = ld * ((lp * lh * bpe * samp + 7) / 8);
      off = off + slices * sb * pd;
    end
    e_total = off;
  endtask

  task automatic apply(input int w, h, d, p, eb, bc, kind, sl, tm, p2, nl);
    in_width = DIM_W'(w); in_height = DIM_W'(h); in_depth = DIM_W'(d);
    in_pitch = DIM_W'(p); in_elem_bits = EB_W'(eb); in_bc = bc[0];
    in_kind = kind[1:0]; in_samples_log2 = sl[1:0]; in_tile_mode = tm[1:0];
    in_pow2 = p2[0]; in_levels = LVL_W'(nl);
  endtask

  task automatic run_cfg(input int w, h, d, p, eb, bc, kind, sl, tm, p2, nl,
                         input string grp, input bit inject);
    model(w, h, d, p, eb, bc, kind, sl, tm, p2, nl);
    @(negedge clk);
    apply(w, h, d, p, eb, bc, kind, sl, tm, p2, nl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({grp, " R2 busy after start"}, busy, 1);
    if (inject) begin
      // R2: a second start during the run with a different width is ignored
      start = 1'b1;
      in_width = in_width + DIM_W'(9);
      in_kind = 2'd1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int L = 0; L < nl; L++) begin
      while (!lvl_done) @(negedge clk);
      chk($sformatf("%s R3 index L%0d", grp, L), lvl_index, L);
      chk($sformatf("%s R9 pitch L%0d", grp, L), lvl_pitch, e_pitch[L]);
      chk($sformatf("%s R8 height L%0d", grp, L), lvl_height, e_height[L]);
      chk($sformatf("%s R8 depth L%0d", grp, L), lvl_depth, e_depth[L]);
      chk($sformatf("%s R11 offset L%0d", grp, L), lvl_offset, e_off[L]);
      chk($sformatf("%s R10 tiled L%0d", grp, L), lvl_tiled, e_tiled[L]);
      chk($sformatf("%s R10 linear L%0d", grp, L), lvl_linear, e_lin[L]);
      if (L == nl - 1) begin
        chk({grp, " R12 all_done with last level"}, all_done, 1);
        chk({grp, " R12 total"}, total_size, e_total);
        chk({grp, " R12 idle at end"}, busy, 0);
        chk({grp, " R5 no error"}, cfg_err, 0);
      end else begin
        chk({grp, " R12 no early all_done"}, all_done, 0);
      end
      @(negedge clk);
    end
  endtask

  task automatic run_err(input int eb, bc, tm, nl, input string tag);
    @(negedge clk);
    apply(20, 12, 2, 24, eb, bc, 0, 0, tm, 0, nl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R5 cfg_err"}, cfg_err, 1);
    chk({tag, " R5 all_done"}, all_done, 1);
    chk({tag, " R5 busy low"}, busy, 0);
    chk({tag, " R5 no level"}, lvl_done, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({tag, " R5 no level later"}, lvl_done, 0);
    end
    chk({tag, " R5 error held"}, cfg_err, 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    string grp;
    int ws[3], hs[3], ds[3], ps[3];
    int ebs[4], bcs[4];
    rst_n = 1'b0;
    start = 1'b0;
    apply(1, 1, 1, 0, 32, 0, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 lvl_done", lvl_done, 0);
    chk("R1 all_done", all_done, 0);
    chk("R1 cfg_err", cfg_err, 0);

    // R5: each rejection cause
    run_err(2, 1, 0, 3, "bc bits 2");
    run_err(16, 1, 0, 3, "bc bits 16");
    run_err(32, 0, 2, 3, "tile mode 2");
    run_err(32, 0, 3, 3, "tile mode 3");
    run_err(32, 0, 0, 0, "zero levels");

    // R2: valid start clears error; mid-run start ignored
    run_cfg(37, 19, 3, 40, 32, 0, 0, 0, 0, 0, 5, "R2 ignore", 1'b1);

    ws = '{37, 8, 100};  hs = '{19, 64, 7};
    ds = '{3, 5, 1};     ps = '{40, 0, 100};
    ebs = '{32, 8, 1, 8}; bcs = '{0, 0, 1, 1};
    for (int kind = 0; kind < 4; kind++)
      for (int tm = 0; tm < 2; tm++)
        for (int p2 = 0; p2 < 2; p2++)
          for (int f = 0; f < 4; f++)
            for (int s = 0; s < 3; s++) begin
              if (bcs[f] != 0)      grp = "R4";
              else if (p2 != 0)     grp = "R6";
              else if (kind == 2)   grp = "R3";
              else                  grp = "R7";
              grp = $sformatf("%s k%0d t%0d p%0d f%0d s%0d", grp, kind, tm, p2, f, s);
              run_cfg(ws[s], hs[s], ds[s], ps[s], ebs[f], bcs[f], kind, 2, tm, p2, 5,
                      grp, 1'b0);
            end

    // R7 with a large mip count so levels clamp to 1
    run_cfg(64, 32, 1, 96, 32, 0, 0, 0, 0, 0, 9, "R7 R3 clamp", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule